// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Timer

This block is a 16-bit timer with three operating modes. In capture mode a rising edge on an event input stores the running count. In compare mode the counter is matched against a reference value; a match can set an interrupt flag and drive a timer output pin, and can optionally restart the count. In event mode the counter advances once per rising edge on the event input instead of on timer ticks.

The timer tick comes from an 8-bit prescaler. The prescaler is fed either by every system clock cycle or by rising edges of an external clock pin. The output pin either drops low for one tick or flips level on each match. Software controls the block through a small write/read register port. Two sticky event flags, one for capture and one for reference match, are cleared by writing ones. Each flag has its own interrupt enable.

Top module: `tmr_top`

Register map: 0 = control, 1 = prescale, 2 = reference, 3 = captured value (read-only), 4 = live count (read-only), 5 = status.

## Requirements
- R1: After reset, the count reads 0, status reads 0, `irq` is 0 and `tmr_out` is 1.
- R2: Without restart, the 16-bit count advances by one per tick and wraps from 0xFFFF to 0x0000.
- R3: A prescale value N (register 1, bits 7:0) gives one tick every N+1 source pulses, so N = 0 ticks on every pulse.
- R4: Control bit 3 = 1 takes source pulses from rising edges of `ext_clk_in`, after a two-flop synchronizer. Bit 3 = 0 uses every system clock.
- R5: Capture mode (control bits 2:1 = 0) works as follows. A rising edge on `evt_in` stores the count into register 3 and sets status bit 0. The stored value is the count two clocks after the input changes, because of the synchronizer.
- R6: In event mode (control bits 2:1 = 2), the count advances by one per rising edge of `evt_in`, whatever the prescale value. A level that stays high adds nothing more.
- R7: In compare mode (control bits 2:1 = 1), the count reaching register 2 sets status bit 1. With restart (control bit 6) set, the next tick after the match loads 0.
- R8: With output enable (bit 5) set and toggle (bit 4) clear, `tmr_out` is low exactly while the count equals the reference after a match. This lasts one prescaled tick.
- R9: With output enable and toggle set, `tmr_out` inverts each time the count reaches the reference.
- R10: Writing 1 to a status bit clears that bit and leaves the others alone. `irq` is the OR of status bit 0 AND control bit 7 with status bit 1 AND control bit 8.
- R11: While enable (control bit 0) is 0, the count and prescaler are held at 0. Event edges are ignored and no capture is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ext_clk_in | input | 1 | External tick source pin |
| evt_in | input | 1 | Capture / event input pin |
| tmr_out | output | 1 | Timer output pin, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The bench predicts the captured value from the synchronizer latency. A design with one flop too many or too few stores a count off by one. The pulse test reads the count and the pin on every cycle. With a larger prescale it measures the low time, so a pulse lasting one system cycle instead of one tick shows up at once. The toggle, wrap at 0xFFFF, restart period and selective write-one-to-clear are each checked at the ports. An event level held high must not keep advancing the count. A block that counts or captures while disabled leaves a nonzero count or a changed capture register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W = 16;
    localparam int TMR_PRE_W = 8;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_COMPARE = 2'd1,
        MODE_EVENT   = 2'd2,
        MODE_RSVD    = 2'd3
    } tmr_mode_e;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_PRESC = 3'd1,
        REG_REF   = 3'd2,
        REG_CAPT  = 3'd3,
        REG_COUNT = 3'd4,
        REG_STAT  = 3'd5
    } tmr_reg_e;

    // bit 0 enable, 2:1 mode, 3 ext source, 4 toggle, 5 out enable,
    // 6 restart, 7 capture irq enable, 8 reference irq enable
    typedef struct packed {
        logic      irq_ref_en;
        logic      irq_cap_en;
        logic      restart;
        logic      out_en;
        logic      out_toggle;
        logic      clk_ext;
        tmr_mode_e mode;
        logic      enable;
    } tmr_ctrl_t;

    typedef struct packed {
        logic ref_hit;
        logic cap_hit;
    } tmr_evt_t;

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_pulse,
    input  logic [PRE_W-1:0] divisor,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic             last;

    assign last = (pre_cnt >= divisor);
    assign tick = run & src_pulse & last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
        end else if (src_pulse) begin
            pre_cnt <= last ? '0 : pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctrl_t        ctrl,
    input  logic             tick,
    input  logic             evt_rise,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] capture,
    output tmr_evt_t         evt,
    output logic             out_level
);
    logic             advance;
    logic             is_cmp;
    logic [CNT_W-1:0] nxt;

    assign is_cmp = (ctrl.mode == MODE_COMPARE);

    always_comb begin
        unique case (ctrl.mode)
            MODE_EVENT: advance = ctrl.enable & evt_rise;
            MODE_RSVD:  advance = 1'b0;
            default:    advance = ctrl.enable & tick;
        endcase
    end

    assign nxt         = (is_cmp && ctrl.restart && cnt == ref_val) ? '0 : cnt + 1'b1;
    assign evt.ref_hit = advance & is_cmp & (nxt == ref_val);
    assign evt.cap_hit = ctrl.enable & (ctrl.mode == MODE_CAPTURE) & evt_rise;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capture <= '0;
        end else if (evt.cap_hit) begin
            capture <= cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            out_level <= 1'b1;
        end else if (advance) begin
            if (ctrl.out_toggle) begin
                out_level <= out_level ^ evt.ref_hit;
            end else begin
                out_level <= ~evt.ref_hit;
            end
        end
    end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = TMR_CNT_W,
    parameter int PRE_W       = TMR_PRE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_clk_in,
    input  logic             evt_in,
    output logic             tmr_out,
    output logic             irq
);
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    tmr_ctrl_t        ctrl_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] ref_q;
    logic             flag_cap;
    logic             flag_ref;
    logic             ext_rise;
    logic             evt_rise;
    logic             src_pulse;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] capture;
    tmr_evt_t         evt;
    logic             out_level;
    logic             stat_wr;

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk_in), .rise(ext_rise)
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst(rst), .din(evt_in), .rise(evt_rise)
    );

    assign src_pulse = ctrl_q.clk_ext ? ext_rise : 1'b1;

    tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl_q.enable), .src_pulse(src_pulse),
        .divisor(presc_q), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .tick(tick), .evt_rise(evt_rise),
        .ref_val(ref_q), .cnt(cnt), .capture(capture), .evt(evt),
        .out_level(out_level)
    );

    assign stat_wr = wr_en && (tmr_reg_e'(wr_addr) == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            ref_q   <= '0;
        end else if (wr_en) begin
            unique case (tmr_reg_e'(wr_addr))
                REG_CTRL:  ctrl_q  <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
                REG_PRESC: presc_q <= wr_data[PRE_W-1:0];
                REG_REF:   ref_q   <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_cap <= 1'b0;
            flag_ref <= 1'b0;
        end else begin
            flag_cap <= sticky_next(flag_cap, evt.cap_hit, stat_wr & wr_data[0]);
            flag_ref <= sticky_next(flag_ref, evt.ref_hit, stat_wr & wr_data[1]);
        end
    end

    always_comb begin
        unique case (tmr_reg_e'(rd_addr))
            REG_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            REG_PRESC: rd_data = {{(CNT_W-PRE_W){1'b0}}, presc_q};
            REG_REF:   rd_data = ref_q;
            REG_CAPT:  rd_data = capture;
            REG_COUNT: rd_data = cnt;
            REG_STAT:  rd_data = {{(CNT_W-2){1'b0}}, flag_ref, flag_cap};
            default:   rd_data = '0;
        endcase
    end

    assign tmr_out = ctrl_q.out_en ? out_level : 1'b1;
    assign irq     = (flag_cap & ctrl_q.irq_cap_en) | (flag_ref & ctrl_q.irq_ref_en);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input tmr_ctrl_t        ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ref_val,
    input logic [CNT_W-1:0] capture,
    input logic             flag_cap,
    input logic             flag_ref,
    input logic             tmr_out
);
    // R11
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> cnt == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

    // R7
    ref_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_COMPARE && $rose(flag_ref)) |-> cnt == ref_val);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.out_en && !ctrl.out_toggle && ctrl.mode == MODE_COMPARE && $fell(tmr_out))
        |-> cnt == ref_val);

    // R5
    capture_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (capture != $past(capture)) |-> flag_cap);
endmodule

bind tmr_top tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .cnt(cnt), .ref_val(ref_q),
    .capture(capture), .flag_cap(flag_cap), .flag_ref(flag_ref), .tmr_out(tmr_out)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
    localparam int CLK_P = 10;

    localparam logic [15:0] C_EN   = 16'h0001;
    localparam logic [15:0] C_CMP  = 16'h0002;
    localparam logic [15:0] C_EVT  = 16'h0004;
    localparam logic [15:0] C_EXT  = 16'h0008;
    localparam logic [15:0] C_TOG  = 16'h0010;
    localparam logic [15:0] C_OEN  = 16'h0020;
    localparam logic [15:0] C_RST  = 16'h0040;
    localparam logic [15:0] C_CIE  = 16'h0080;
    localparam logic [15:0] C_RIE  = 16'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_clk_in = 1'b0;
    logic        evt_in = 1'b0;
    logic        tmr_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_in(ext_clk_in),
        .evt_in(evt_in), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_evt(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1; wait_cyc(3);
            evt_in = 1'b0; wait_cyc(3);
        end
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; wait_cyc(3);
            ext_clk_in = 1'b0; wait_cyc(3);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd4, v); check("R1 count", v, 0);
        rd(3'd5, v); check("R1 status", v, 0);
        check("R1 irq", irq, 0);
        check("R1 tmr_out", tmr_out, 1);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd0, C_EN);
        wait_cyc(7);
        rd(3'd4, v); check("R3 divide by 1", v, 7);
        wr(3'd0, 0); wr(3'd1, 3); wr(3'd0, C_EN);
        wait_cyc(40);
        rd(3'd4, v); check("R3 divide by 4", v, 10);
    endtask

    task automatic t_extclk;
        logic [15:0] v;
        wr(3'd0, 0); wr(3'd1, 1); wr(3'd0, C_EN | C_EXT);
        wait_cyc(10);
        rd(3'd4, v); check("R4 no ext edges", v, 0);
        pulse_ext(6);
        wait_cyc(5);
        rd(3'd4, v); check("R4 ext edges / 2", v, 3);
    endtask

    task automatic t_capture;
        logic [15:0] c, v;
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd5, 16'h3); wr(3'd0, C_EN);
        wait_cyc(20);
        rd(3'd4, c);
        evt_in = 1'b1;
        wait_cyc(5);
        rd(3'd3, v); check("R5 captured value", v, c + 2);
        rd(3'd5, v); check("R5 capture flag", v, 1);
        check("R10 irq masked", irq, 0);
        wr(3'd0, C_EN | C_CIE);
        check("R10 irq enabled", irq, 1);
        wr(3'd5, 16'h1);
        rd(3'd5, v); check("R10 w1c capture", v, 0);
        check("R10 irq cleared", irq, 0);
        evt_in = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_event;
        logic [15:0] v;
        wr(3'd0, 0); wr(3'd1, 5); wr(3'd0, C_EN | C_EVT);
        pulse_evt(4);
        wait_cyc(5);
        rd(3'd4, v); check("R6 event count", v, 4);
        evt_in = 1'b1; wait_cyc(20);
        rd(3'd4, v); check("R6 held level", v, 5);
        evt_in = 1'b0; wait_cyc(4);
    endtask

    task automatic t_pulse;
        logic [15:0] v;
        int bad, lows;
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 5); wr(3'd5, 16'h3);
        wr(3'd0, C_EN | C_CMP | C_RST | C_OEN | C_RIE);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            rd(3'd4, v);
            if (v > 5) bad++;
            if ((tmr_out == 1'b0) != (v == 5)) bad++;
            wait_cyc(1);
        end
        check("R7 restart period / R8 pulse", bad, 0);
        rd(3'd5, v); check("R7 ref flag", v, 2);
        check("R10 irq ref", irq, 1);
        wr(3'd5, 16'h1);
        rd(3'd5, v); check("R10 w1c leaves ref flag", v[1], 1);
        wr(3'd0, 0); wr(3'd1, 2);
        wr(3'd0, C_EN | C_CMP | C_RST | C_OEN);
        wait_cyc(5);
        lows = 0;
        for (int i = 0; i < 36; i++) begin
            if (tmr_out == 1'b0) lows++;
            wait_cyc(1);
        end
        check("R8 pulse is one tick", lows, 6);
    endtask

    task automatic t_toggle;
        logic [15:0] v, pv;
        logic e;
        int bad;
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 3);
        wr(3'd0, C_EN | C_CMP | C_RST | C_OEN | C_TOG);
        e = 1'b1; pv = 16'hFFFF; bad = 0;
        for (int i = 0; i < 25; i++) begin
            rd(3'd4, v);
            if (v == 3 && pv != 3) e = ~e;
            if (tmr_out !== e) bad++;
            pv = v;
            wait_cyc(1);
        end
        check("R9 toggle", bad, 0);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd0, C_EN);
        wait_cyc(65535);
        rd(3'd4, v); check("R2 top value", v, 16'hFFFF);
        wait_cyc(1);
        rd(3'd4, v); check("R2 wrap", v, 0);
    endtask

    task automatic t_disabled;
        logic [15:0] c0, v;
        wr(3'd0, C_EVT);
        rd(3'd3, c0);
        pulse_evt(3);
        wait_cyc(5);
        rd(3'd4, v); check("R11 count held", v, 0);
        wr(3'd0, 0);
        pulse_evt(2);
        wait_cyc(5);
        rd(3'd3, v); check("R11 no capture", v, c0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_extclk();
        t_capture();
        t_event();
        t_pulse();
        t_toggle();
        t_wrap();
        t_disabled();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule